// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into bytes. A 16x enable from an external baud generator paces a frame state machine. The machine finds the start bit, samples each later bit at its centre and checks parity. It also catches framing errors and line breaks. Every finished character goes into a receive queue together with its own error flags. The consumer therefore learns about a fault when it reads the faulty byte, and not before.

The queue holds up to 32 entries. A mode input can shrink it to one entry, which behaves as a plain holding register. When a character arrives and the queue is full, the character is dropped and a sticky overrun flag is raised. The stored data is never overwritten. An optional flow-control output tells the remote sender to pause once the fill level reaches a programmed threshold. Three interrupt sources (data present, receive timeout, error) each pass through their own enable bit and are combined into one request line.

The frame state machine has seven states. IDLE waits for a low line and moves to START. START re-reads the line after 8 ticks: a high line returns to IDLE (false start), and a low line moves to DATA. DATA samples one bit every 16 ticks and, after the last data bit, moves to PARITY if parity is enabled or to STOP1 otherwise. PARITY moves to STOP1. STOP1 moves to STOP2 when two stop bits are selected. Otherwise it moves to BRKWAIT when a break was seen, or to IDLE. STOP2 moves to BRKWAIT or IDLE by the same break rule. BRKWAIT stays until the line returns high, then moves to IDLE.

Top module: `uart_err_rx`

## Requirements
- R1: Data bits arrive least significant bit first. `len_sel` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. A shorter character is right-aligned in `rd_data` with its upper bits zero. Parity (`par_en`, with `par_odd`=1 for odd) is optional, and `stop2`=1 selects two stop bits.
- R2: A falling edge starts a frame only if the line is still low 8 ticks later. A shorter low pulse returns the receiver to IDLE and stores no entry.
- R3: When parity is enabled, a parity bit that does not match the chosen sense stores the entry with `rd_perr`=1. A matching parity bit stores `rd_perr`=0.
- R4: A stop bit sampled low stores the entry with `rd_ferr`=1.
- R5: A break stores exactly one entry with data 0, `rd_brk`=1 and `rd_ferr`=1. A break means all data bits, the parity bit (if enabled) and the first stop bit are sampled low. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: The queue keeps arrival order. `rd_valid` shows that an entry is present, and the head entry appears on the `rd_*` outputs. A one-cycle `rd_en` pops the head. A pop of an empty queue changes nothing.
- R7: A character that completes while the queue is full, with no pop in that cycle, is dropped. `overrun` rises on the next cycle, and stored entries and `rd_count` stay unchanged. `overrun` stays high until `ovr_clr` is pulsed.
- R8: With `single_mode`=1 the queue holds at most one entry, and a second character arriving before the pop is an overrun.
- R9: With `flow_en`=1, `rts_n` is high while `rd_count` is at least `rts_level` (1 in single mode) and low otherwise. With `flow_en`=0 it is always low.
- R10: `irq_src[1]` (timeout) rises after 32 bit times (512 ticks) during which the queue is non-empty and the receiver is idle. A pop clears it.
- R11: `irq_src[0]` shows that the queue is non-empty. `irq_src[2]` shows overrun, or an error flag on the head entry. `irq` is high exactly when a source bit is set and its `irq_en` bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| rxd | input | 1 | Serial input line, idle high |
| len_sel | input | 2 | Character length code (00=5 ... 11=8) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop2 | input | 1 | Two stop bits |
| single_mode | input | 1 | Limit the queue to one entry |
| flow_en | input | 1 | Enable automatic flow control |
| rts_level | input | 6 | Fill level at which `rts_n` goes high |
| irq_en | input | 3 | Interrupt enables {error, timeout, data} |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_en | input | 1 | Pop the head entry |
| rd_valid | output | 1 | Queue is not empty |
| rd_data | output | 8 | Head entry data |
| rd_ferr | output | 1 | Head entry framing error |
| rd_perr | output | 1 | Head entry parity error |
| rd_brk | output | 1 | Head entry break |
| rd_count | output | 6 | Number of stored entries |
| overrun | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Flow-control output, high asks the sender to pause |
| irq_src | output | 3 | Raw interrupt sources {error, timeout, data} |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The hardest case to reach is the overrun path. It needs 32 complete characters stored without a pop, then one more character whose stop-bit completion lands on a full queue. The bench sends 33 distinct bytes back to back and checks `rd_count` and `overrun`. It then drains the queue and checks that the last entry read is the 32nd byte and not the 33rd. A framing error that leaves the line low into the next bit time is also shaped on purpose. The false start that follows must be rejected, and the bench confirms this by seeing exactly one stored entry.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2,
        RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       perr;
        logic       ferr;
        logic [7:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } line_cfg_t;

endpackage

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    input  line_cfg_t cfg,
    output logic      push,
    output rx_entry_t entry,
    output logic      busy
);

    logic       rx_m, rx_s;
    rx_state_e  state, nxt;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] shreg;
    logic       perr_r, seen_one, stop1_low;
    logic       mid_start, bit_end, exp_par, first_low, brk_hit;
    logic [2:0] last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    assign mid_start = tick && (tcnt == 4'd7);
    assign bit_end   = tick && (tcnt == 4'd15);
    assign last_idx  = {1'b0, cfg.len_sel} + 3'd4;
    assign exp_par   = (^shreg) ^ cfg.par_odd;
    assign first_low = (state == RX_STOP1) ? !rx_s : stop1_low;
    assign brk_hit   = !seen_one && first_low;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:    if (!rx_s) nxt = RX_START;
            RX_START:   if (mid_start) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:    if (bit_end && bidx == last_idx)
                            nxt = cfg.par_en ? RX_PARITY : RX_STOP1;
            RX_PARITY:  if (bit_end) nxt = RX_STOP1;
            RX_STOP1:   if (bit_end)
                            nxt = cfg.stop2 ? RX_STOP2 :
                                  (brk_hit ? RX_BRKWAIT : RX_IDLE);
            RX_STOP2:   if (bit_end) nxt = brk_hit ? RX_BRKWAIT : RX_IDLE;
            RX_BRKWAIT: if (rx_s) nxt = RX_IDLE;
            default:    nxt = RX_IDLE;
        endcase
    end

    // bit timing and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            perr_r    <= 1'b0;
            seen_one  <= 1'b0;
            stop1_low <= 1'b0;
        end else if (state == RX_IDLE) begin
            tcnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            perr_r    <= 1'b0;
            seen_one  <= 1'b0;
            stop1_low <= 1'b0;
        end else begin
            if (tick) begin
                if (state == RX_START && tcnt == 4'd7) tcnt <= '0;
                else                                   tcnt <= tcnt + 4'd1;
            end
            if (state == RX_DATA && bit_end) begin
                shreg[bidx] <= rx_s;
                bidx        <= bidx + 3'd1;
                if (rx_s) seen_one <= 1'b1;
            end
            if (state == RX_PARITY && bit_end) begin
                perr_r <= (rx_s != exp_par);
                if (rx_s) seen_one <= 1'b1;
            end
            if (state == RX_STOP1 && bit_end) stop1_low <= !rx_s;
        end
    end

    // outputs
    always_comb begin
        push       = bit_end && ((state == RX_STOP1 && !cfg.stop2) ||
                                 (state == RX_STOP2));
        entry.data = shreg;
        entry.perr = perr_r;
        entry.ferr = (state == RX_STOP1) ? !rx_s : (stop1_low || !rx_s);
        entry.brk  = brk_hit;
        busy       = (state != RX_IDLE);
    end

    // R2
    fstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && mid_start && rx_s) |=> (state == RX_IDLE && !push));

    // R5
    brkwait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BRKWAIT && !rx_s) |=> !push);

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_entry_t     wr_entry,
    input  logic          pop,
    input  logic          single,
    input  logic          ovr_clr,
    output rx_entry_t     head,
    output logic [CW-1:0] count,
    output logic          overrun
);

    rx_entry_t         mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic              full, pop_ok, accept;

    assign full   = single ? (count != '0) : (count == CW'(DEPTH));
    assign pop_ok = pop && (count != '0);
    assign accept = push && (!full || pop_ok);

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (accept && !pop_ok)      count <= count + 1'b1;
            else if (!accept && pop_ok) count <= count - 1'b1;
            if (push && !accept)        overrun <= 1'b1;
            else if (ovr_clr)           overrun <= 1'b0;
        end
    end

    assign head = mem[rptr];

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> overrun);

    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

    // R8
    single_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single && count <= CW'(1)) |=> (count <= CW'(1)));

endmodule

// File: rtl/urx_irq.sv
module urx_irq #(
    parameter int TOUT_BITS = 32,
    localparam int TT = TOUT_BITS * 16,
    localparam int TW = $clog2(TT + 1)
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       busy,
    input  logic       nonempty,
    input  logic       pop,
    input  logic       head_err,
    input  logic       overrun,
    input  logic [2:0] en,
    output logic [2:0] src,
    output logic       irq
);

    logic [TW-1:0] tcount;
    logic          tout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcount <= '0;
            tout   <= 1'b0;
        end else if (pop || !nonempty) begin
            tcount <= '0;
            tout   <= 1'b0;
        end else if (busy) begin
            tcount <= '0;
        end else if (tick && !tout) begin
            if (tcount == TW'(TT - 1)) begin
                tout   <= 1'b1;
                tcount <= '0;
            end else begin
                tcount <= tcount + 1'b1;
            end
        end
    end

    always_comb begin
        src[0] = nonempty;
        src[1] = tout;
        src[2] = overrun || (nonempty && head_err);
        irq    = |(src & en);
    end

    // R10
    tout_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !tout);

endmodule

// File: rtl/uart_err_rx.sv
module uart_err_rx
    import urx_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int TOUT_BITS = 32,
    localparam int CW = $clog2(DEPTH + 1)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic [1:0]    len_sel,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          stop2,
    input  logic          single_mode,
    input  logic          flow_en,
    input  logic [CW-1:0] rts_level,
    input  logic [2:0]    irq_en,
    input  logic          ovr_clr,
    input  logic          rd_en,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          rd_ferr,
    output logic          rd_perr,
    output logic          rd_brk,
    output logic [CW-1:0] rd_count,
    output logic          overrun,
    output logic          rts_n,
    output logic [2:0]    irq_src,
    output logic          irq
);

    line_cfg_t     cfg;
    rx_entry_t     new_entry, head;
    logic          push, busy, head_err;
    logic [CW-1:0] thr;

    assign cfg = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd, stop2: stop2};

    urx_frame u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .rxd   (rxd),
        .cfg   (cfg),
        .push  (push),
        .entry (new_entry),
        .busy  (busy)
    );

    urx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wr_entry (new_entry),
        .pop      (rd_en),
        .single   (single_mode),
        .ovr_clr  (ovr_clr),
        .head     (head),
        .count    (rd_count),
        .overrun  (overrun)
    );

    assign head_err = head.ferr || head.perr || head.brk;

    urx_irq #(.TOUT_BITS(TOUT_BITS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .busy     (busy),
        .nonempty (rd_valid),
        .pop      (rd_en),
        .head_err (head_err),
        .overrun  (overrun),
        .en       (irq_en),
        .src      (irq_src),
        .irq      (irq)
    );

    always_comb begin
        rd_valid = (rd_count != '0);
        rd_data  = head.data;
        rd_ferr  = head.ferr;
        rd_perr  = head.perr;
        rd_brk   = head.brk;
        thr      = single_mode ? CW'(1) : rts_level;
        rts_n    = flow_en && (rd_count >= thr);
    end

    // R9
    rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |-> !rts_n);

endmodule

// File: tb/test_uart_err_rx.sv
`timescale 1ns/1ps
module test_uart_err_rx;

    localparam int BIT = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
    logic       single_mode = 1'b0, flow_en = 1'b0;
    logic [5:0] rts_level = 6'd28;
    logic [2:0] irq_en = 3'b000;
    logic       ovr_clr = 1'b0, rd_en = 1'b0;
    logic       rd_valid, rd_ferr, rd_perr, rd_brk, overrun, rts_n, irq;
    logic [7:0] rd_data;
    logic [5:0] rd_count;
    logic [2:0] irq_src;

    int checks = 0;
    int errors = 0;
    logic [1:0] tdiv = 2'd0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    uart_err_rx i_uart_err_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
        .single_mode(single_mode), .flow_en(flow_en), .rts_level(rts_level),
        .irq_en(irq_en), .ovr_clr(ovr_clr), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ferr(rd_ferr),
        .rd_perr(rd_perr), .rd_brk(rd_brk), .rd_count(rd_count),
        .overrun(overrun), .rts_n(rts_n), .irq_src(irq_src), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        rxd = b;
        wait_clk(BIT);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit bad_par, input bit bad_stop);
        logic [7:0] m;
        m = 8'hFF >> (8 - nb);
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) bit_out(d[i]);
        if (par_en) bit_out((^(d & m)) ^ par_odd ^ bad_par);
        if (bad_stop) begin
            rxd = 1'b0; wait_clk(40);
            rxd = 1'b1; wait_clk(24);
        end else begin
            bit_out(1'b1);
        end
        if (stop2) bit_out(1'b1);
        wait_clk(8);
    endtask

    task automatic pop_chk(input string req, input logic [7:0] d,
                           input logic fe, input logic pe, input logic bk);
        chk(req, rd_valid, 1'b1);
        chk(req, {rd_brk, rd_perr, rd_ferr, rd_data}, {bk, pe, fe, d});
        rd_en = 1'b1; wait_clk(1); rd_en = 1'b0;
    endtask

    task automatic set_fmt(input logic [1:0] l, input logic pe, input logic po, input logic s2);
        len_sel = l; par_en = pe; par_odd = po; stop2 = s2;
    endtask

    task automatic t_reset;
        chk("R6 reset valid", rd_valid, 1'b0);
        chk("R6 reset count", rd_count, 6'd0);
        chk("R7 reset overrun", overrun, 1'b0);
        chk("R9 reset rts", rts_n, 1'b0);
        chk("R11 reset irq", {irq, irq_src}, 4'h0);
        rd_en = 1'b1; wait_clk(1); rd_en = 1'b0; wait_clk(1);
        chk("R6 pop empty ignored", rd_count, 6'd0);
    endtask

    task automatic t_formats;
        set_fmt(2'b11, 0, 0, 0);
        send(8'hA5, 8, 0, 0);
        chk("R1 8N1 count", rd_count, 6'd1);
        pop_chk("R1 8N1 byte", 8'hA5, 0, 0, 0);
        chk("R6 empty after pop", rd_count, 6'd0);
        set_fmt(2'b10, 1, 0, 0);
        send(8'h35, 7, 0, 0);
        pop_chk("R1 R3 7E1 byte", 8'h35, 0, 0, 0);
        set_fmt(2'b00, 1, 1, 1);
        send(8'hF3, 5, 0, 0);
        pop_chk("R1 R3 5O2 byte aligned", 8'h13, 0, 0, 0);
        set_fmt(2'b01, 0, 0, 1);
        send(8'h2C, 6, 0, 0);
        pop_chk("R1 6N2 byte", 8'h2C, 0, 0, 0);
    endtask

    task automatic t_parity;
        set_fmt(2'b11, 1, 0, 0);
        send(8'h81, 8, 1, 0);
        pop_chk("R3 even parity error", 8'h81, 0, 1, 0);
        set_fmt(2'b11, 1, 1, 0);
        send(8'h07, 8, 1, 0);
        pop_chk("R3 odd parity error", 8'h07, 0, 1, 0);
        set_fmt(2'b11, 0, 0, 0);
    endtask

    task automatic t_framing;
        send(8'h55, 8, 0, 1);
        wait_clk(BIT);
        chk("R4 R2 framing single entry", rd_count, 6'd1);
        pop_chk("R4 framing flag", 8'h55, 1, 0, 0);
    endtask

    task automatic t_break;
        rxd = 1'b0; wait_clk(BIT * 12);
        chk("R5 break one entry while low", rd_count, 6'd1);
        rxd = 1'b1; wait_clk(BIT * 2);
        chk("R5 break one entry after", rd_count, 6'd1);
        pop_chk("R5 break entry", 8'h00, 1, 0, 1);
        send(8'h3C, 8, 0, 0);
        pop_chk("R5 receive after break", 8'h3C, 0, 0, 0);
    endtask

    task automatic t_false_start;
        rxd = 1'b0; wait_clk(12);
        rxd = 1'b1; wait_clk(BIT * 12);
        chk("R2 false start no entry", rd_count, 6'd0);
    endtask

    task automatic t_overrun;
        for (int i = 1; i <= 32; i++) send(8'(i), 8, 0, 0);
        chk("R6 full count", rd_count, 6'd32);
        chk("R7 no overrun yet", overrun, 1'b0);
        send(8'hEE, 8, 0, 0);
        chk("R7 overrun set", overrun, 1'b1);
        chk("R7 count unchanged", rd_count, 6'd32);
        irq_en = 3'b000; wait_clk(1);
        chk("R11 masked irq low", irq, 1'b0);
        chk("R11 error source", irq_src[2], 1'b1);
        irq_en = 3'b100; wait_clk(1);
        chk("R11 error irq", irq, 1'b1);
        irq_en = 3'b000;
        for (int i = 1; i <= 32; i++) pop_chk("R6 R7 order kept", 8'(i), 0, 0, 0);
        chk("R7 overrun sticky", overrun, 1'b1);
        ovr_clr = 1'b1; wait_clk(1); ovr_clr = 1'b0; wait_clk(1);
        chk("R7 overrun cleared", overrun, 1'b0);
    endtask

    task automatic t_single;
        single_mode = 1'b1;
        send(8'h11, 8, 0, 0);
        send(8'h22, 8, 0, 0);
        chk("R8 single count", rd_count, 6'd1);
        chk("R8 single overrun", overrun, 1'b1);
        pop_chk("R8 first kept", 8'h11, 0, 0, 0);
        ovr_clr = 1'b1; wait_clk(1); ovr_clr = 1'b0;
        single_mode = 1'b0;
    endtask

    task automatic t_rts;
        flow_en = 1'b1; rts_level = 6'd4;
        for (int i = 0; i < 3; i++) send(8'h40 + 8'(i), 8, 0, 0);
        chk("R9 rts low below level", rts_n, 1'b0);
        send(8'h43, 8, 0, 0);
        chk("R9 rts high at level", rts_n, 1'b1);
        pop_chk("R9 pop", 8'h40, 0, 0, 0);
        chk("R9 rts low after pop", rts_n, 1'b0);
        for (int i = 1; i < 4; i++) pop_chk("R9 drain", 8'h40 + 8'(i), 0, 0, 0);
        flow_en = 1'b0; rts_level = 6'd28;
    endtask

    task automatic t_timeout;
        irq_en = 3'b010;
        send(8'h99, 8, 0, 0);
        wait_clk(1500);
        chk("R10 no timeout early", {irq, irq_src[1]}, 2'b00);
        wait_clk(700);
        chk("R10 timeout source", irq_src[1], 1'b1);
        chk("R10 R11 timeout irq", irq, 1'b1);
        chk("R11 data source", irq_src[0], 1'b1);
        pop_chk("R10 byte", 8'h99, 0, 0, 0);
        chk("R10 cleared by read", {irq, irq_src[1]}, 2'b00);
        irq_en = 3'b000;
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset;
        t_formats;
        t_parity;
        t_framing;
        t_break;
        t_false_start;
        t_overrun;
        t_single;
        t_rts;
        t_timeout;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule